// File: doc/BRIEF.md
# Dual-Channel Disk Controller I/O Window Decoder

This block sits between a host I/O port bus and the register files of a two-channel disk controller. For each host access it decides which channel and which window (command block or control block) the address falls in. It then applies the claiming rules that depend on access width, and raises exactly one strobe: a task-file byte strobe, a data-port strobe or a control strobe. Each strobe carries a channel index and a register offset. Read data comes back from the register file on `bk_rdata`. The block masks it to the access width, or returns all ones when no window claims the access.

A two-state machine holds the decode mode. State `ST_LEGACY` decodes the fixed legacy port bases. State `ST_NATIVE` decodes relocatable windows whose bases arrive on input ports. Transition `T_ENTER_NATIVE` fires when a programming-interface byte is written with low nibble 0xF. Transition `T_ENTER_LEGACY` fires on low nibble 0xA. Any other written nibble takes transition `T_HOLD` and leaves the state as it was. The reported interrupt-pin value follows the state.

Top module: `ide_io_window_dec`

## Requirements
- R1: After reset the decoder is in legacy mode and `irq_pin` is 0.
- R2: A write on `cfg_we` whose `cfg_progif[3:0]` is 0xF selects native mode and sets `irq_pin` to 1 from the next cycle. A nibble of 0xA selects legacy mode and sets `irq_pin` to 0. Bits 7:4 are ignored.
- R3: A write of any other low nibble leaves the mode and `irq_pin` unchanged.
- R4: In legacy mode the windows sit at fixed bases. Channel 0 has its command window at 0x1F0-0x1F7 and its control window at 0x3F4-0x3F7. Channel 1 has its command window at 0x170-0x177 and its control window at 0x374-0x377. The native base inputs have no effect.
- R5: In native mode the command window of channel n is the 8 bytes at `nat_cmd_base<n>` with the low 3 base bits ignored. The control window is the 4 bytes at `nat_ctl_base<n>` with the low 2 base bits ignored. Legacy addresses are not decoded.
- R6: A control window claims only a one-byte access (`io_size`=0) at offset 2. A read there raises `ctl_stb` for alternate status, and a write raises it for device control, with `stb_off`=2. Every other access in the window is unclaimed.
- R7: A one-byte access anywhere in a command window raises `tf_stb` with `stb_off` equal to `io_addr[2:0]`.
- R8: A wider access in a command window is claimed only at offset 0, where it raises `data_stb` with `stb_off`=0. Here `io_size` 1 means 2 bytes, and 2 or 3 means 4 bytes. At any other offset the access is unclaimed.
- R9: An unclaimed read returns all ones over the access width (0xFF, 0xFFFF or 0xFFFFFFFF) with higher bits zero. An unclaimed write raises no strobe. A claimed read returns `bk_rdata` masked to the access width.
- R10: At most one strobe is high. If windows overlap, the first window that matches wins, in the order channel 0 command, channel 0 control, channel 1 command, channel 1 control, even when that window does not claim the access. `stb_chan` and `stb_off` are 0 when no strobe is high.
- R11: Without `io_req` no strobe is high. `io_rdata` is zero unless a read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Programming-interface byte write |
| cfg_progif | input | 8 | Programming-interface byte value |
| nat_cmd_base0 | input | 16 | Native command window base, channel 0 |
| nat_ctl_base0 | input | 16 | Native control window base, channel 0 |
| nat_cmd_base1 | input | 16 | Native command window base, channel 1 |
| nat_ctl_base1 | input | 16 | Native control window base, channel 1 |
| io_req | input | 1 | Host access present this cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_size | input | 2 | Width code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| io_addr | input | 16 | Host I/O address |
| bk_rdata | input | 32 | Read data from the addressed register |
| io_rdata | output | 32 | Read data returned to the host |
| tf_stb | output | 1 | Task-file byte register strobe |
| data_stb | output | 1 | Data-port strobe |
| ctl_stb | output | 1 | Alternate-status / device-control strobe |
| stb_chan | output | 1 | Channel index of the strobe |
| stb_off | output | 3 | Register offset of the strobe |
| irq_pin | output | 1 | Reported interrupt-pin value |

## Verification
The main patterns are sweeps of every byte of all eight candidate windows, legacy and native, in both modes, across all four width codes and both directions. These sweeps separate width-based claiming from offset-based claiming, and active bases from inactive ones. A second configuration overlaps the native windows and gives the base inputs misaligned low bits. It separates first-match priority from claim-based fallthrough and confirms the base alignment. Mode writes with nibbles 0xA, 0xF and others, each with varied upper bits, separate the two real transitions from the hold case. Accesses with `io_req` low confirm that the outputs stay quiet.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
    localparam int N_CHAN      = 2;
    localparam int N_WIN       = 2 * N_CHAN;
    localparam int CMD_SPAN_LG = 3;
    localparam int CTL_SPAN_LG = 2;
    localparam int DATA_W      = 32;

    localparam logic [15:0] LEG_CMD0 = 16'h01F0;
    localparam logic [15:0] LEG_CTL0 = 16'h03F4;
    localparam logic [15:0] LEG_CMD1 = 16'h0170;
    localparam logic [15:0] LEG_CTL1 = 16'h0374;

    localparam logic [1:0] CTL_CLAIM_OFF = 2'd2;

    typedef enum logic [0:0] {
        ST_LEGACY = 1'b0,
        ST_NATIVE = 1'b1
    } dec_mode_e;

    typedef enum logic [1:0] {
        SZ_B1  = 2'd0,
        SZ_B2  = 2'd1,
        SZ_B4  = 2'd2,
        SZ_B4X = 2'd3
    } acc_size_e;
endpackage

// File: rtl/ide_mode_fsm.sv
module ide_mode_fsm
    import ide_dec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_progif,
    output dec_mode_e  mode,
    output logic       irq_pin
);
    dec_mode_e  state_q, state_nx;
    logic [7:0] prog_lo;

    assign prog_lo = cfg_progif & 8'h0F;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LEGACY;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        if (cfg_we) begin
            unique case (prog_lo)
                8'h0A:   state_nx = ST_LEGACY;  // T_ENTER_LEGACY
                8'h0F:   state_nx = ST_NATIVE;  // T_ENTER_NATIVE
                default: state_nx = state_q;    // T_HOLD
            endcase
        end
    end

    always_comb begin
        mode = state_q;
        unique case (state_q)
            ST_LEGACY: irq_pin = 1'b0;
            ST_NATIVE: irq_pin = 1'b1;
            default:   irq_pin = 1'b0;
        endcase
    end

    a_r2_enter_native: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_progif[3:0] == 4'hF) |=> irq_pin);
    a_r2_enter_legacy: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_progif[3:0] == 4'hA) |=> !irq_pin);
    a_r3_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we || (cfg_progif[3:0] != 4'hA && cfg_progif[3:0] != 4'hF))
            |=> irq_pin == $past(irq_pin));
endmodule

// File: rtl/ide_win_match.sv
module ide_win_match #(
    parameter int ADDR_W  = 16,
    parameter int SPAN_LG = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    output logic              hit
);
    localparam int TAG_W = ADDR_W - SPAN_LG;
    logic [ADDR_W-1:0] diff;

    assign diff = addr ^ base;
    assign hit  = (diff[ADDR_W-1:SPAN_LG] == TAG_W'(0));
endmodule

// File: rtl/ide_claim.sv
module ide_claim
    import ide_dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [1:0]       size,
    input  logic [2:0]       off_in,
    input  logic [N_WIN-1:0] hit,
    output logic             tf_stb,
    output logic             data_stb,
    output logic             ctl_stb,
    output logic             stb_chan,
    output logic [2:0]       stb_off
);
    localparam int SEL_W = $clog2(N_WIN);

    logic [SEL_W-1:0] sel;
    logic             any_hit;
    logic             is_byte;

    always_comb begin
        sel     = '0;
        any_hit = 1'b0;
        for (int w = N_WIN - 1; w >= 0; w--) begin
            if (hit[w]) begin
                sel     = SEL_W'(w);
                any_hit = 1'b1;
            end
        end
    end

    assign is_byte = (size == SZ_B1);

    always_comb begin
        tf_stb   = 1'b0;
        data_stb = 1'b0;
        ctl_stb  = 1'b0;
        stb_off  = 3'd0;
        if (req && any_hit) begin
            if (!sel[0]) begin
                if (is_byte) begin
                    tf_stb  = 1'b1;
                    stb_off = off_in;
                end else if (off_in == 3'd0) begin
                    data_stb = 1'b1;
                end
            end else if (is_byte && off_in[1:0] == CTL_CLAIM_OFF) begin
                ctl_stb = 1'b1;
                stb_off = {1'b0, CTL_CLAIM_OFF};
            end
        end
        stb_chan = (tf_stb | data_stb | ctl_stb) ? sel[SEL_W-1] : 1'b0;
    end

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tf_stb, data_stb, ctl_stb}));
    a_r8_wide_data_only: assert property (@(posedge clk) disable iff (!rst_n)
        (size != SZ_B1) |-> (!tf_stb && !ctl_stb && (!data_stb || stb_off == 3'd0)));
    a_r6_ctl_byte_off2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_stb |-> (size == SZ_B1 && stb_off == 3'd2 && off_in[1:0] == 2'd2));
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> !(tf_stb || data_stb || ctl_stb));
endmodule

// File: rtl/ide_io_window_dec.sv
module ide_io_window_dec
    import ide_dec_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_progif,
    input  logic [ADDR_W-1:0] nat_cmd_base0,
    input  logic [ADDR_W-1:0] nat_ctl_base0,
    input  logic [ADDR_W-1:0] nat_cmd_base1,
    input  logic [ADDR_W-1:0] nat_ctl_base1,
    input  logic              io_req,
    input  logic              io_wr,
    input  logic [1:0]        io_size,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [31:0]       bk_rdata,
    output logic [31:0]       io_rdata,
    output logic              tf_stb,
    output logic              data_stb,
    output logic              ctl_stb,
    output logic              stb_chan,
    output logic [2:0]        stb_off,
    output logic              irq_pin
);
    dec_mode_e         mode;
    logic [ADDR_W-1:0] cmd_base [N_CHAN];
    logic [ADDR_W-1:0] ctl_base [N_CHAN];
    logic [ADDR_W-1:0] nat_cmd  [N_CHAN];
    logic [ADDR_W-1:0] nat_ctl  [N_CHAN];
    logic [ADDR_W-1:0] leg_cmd  [N_CHAN];
    logic [ADDR_W-1:0] leg_ctl  [N_CHAN];
    logic [N_WIN-1:0]  hit;
    logic [31:0]       width_mask;
    logic              claimed;

    assign nat_cmd[0] = nat_cmd_base0;
    assign nat_ctl[0] = nat_ctl_base0;
    assign nat_cmd[1] = nat_cmd_base1;
    assign nat_ctl[1] = nat_ctl_base1;
    assign leg_cmd[0] = ADDR_W'(LEG_CMD0);
    assign leg_ctl[0] = ADDR_W'(LEG_CTL0);
    assign leg_cmd[1] = ADDR_W'(LEG_CMD1);
    assign leg_ctl[1] = ADDR_W'(LEG_CTL1);

    ide_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_progif (cfg_progif),
        .mode       (mode),
        .irq_pin    (irq_pin)
    );

    for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
        assign cmd_base[ch] = (mode == ST_NATIVE) ? nat_cmd[ch] : leg_cmd[ch];
        assign ctl_base[ch] = (mode == ST_NATIVE) ? nat_ctl[ch] : leg_ctl[ch];

        ide_win_match #(.ADDR_W(ADDR_W), .SPAN_LG(CMD_SPAN_LG)) u_cmd_win (
            .addr (io_addr),
            .base (cmd_base[ch]),
            .hit  (hit[2*ch])
        );
        ide_win_match #(.ADDR_W(ADDR_W), .SPAN_LG(CTL_SPAN_LG)) u_ctl_win (
            .addr (io_addr),
            .base (ctl_base[ch]),
            .hit  (hit[2*ch+1])
        );
    end

    ide_claim u_claim (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (io_req),
        .size     (io_size),
        .off_in   (io_addr[2:0]),
        .hit      (hit),
        .tf_stb   (tf_stb),
        .data_stb (data_stb),
        .ctl_stb  (ctl_stb),
        .stb_chan (stb_chan),
        .stb_off  (stb_off)
    );

    always_comb begin
        unique case (io_size)
            SZ_B1:   width_mask = 32'h0000_00FF;
            SZ_B2:   width_mask = 32'h0000_FFFF;
            default: width_mask = 32'hFFFF_FFFF;
        endcase
    end

    assign claimed  = tf_stb | data_stb | ctl_stb;
    assign io_rdata = (io_req && !io_wr)
                      ? (claimed ? (bk_rdata & width_mask) : width_mask)
                      : 32'h0;

    a_r9_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_wr && io_size == SZ_B1) |-> io_rdata[31:8] == 24'h0);
    a_r11_write_no_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr || !io_req) |-> io_rdata == 32'h0);
endmodule

// File: tb/ide_io_window_dec_tb.sv
module ide_io_window_dec_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_progif = 8'h00;
    logic [15:0] c0 = 16'hC000, k0 = 16'hC008, c1 = 16'hD000, k1 = 16'hD104;
    logic        io_req = 1'b0, io_wr = 1'b0;
    logic [1:0]  io_size = 2'd0;
    logic [15:0] io_addr = 16'h0;
    logic [31:0] bk_rdata, io_rdata;
    logic        tf_stb, data_stb, ctl_stb, stb_chan, irq_pin;
    logic [2:0]  stb_off;
    int          n_run = 0, n_fail = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;
    assign bk_rdata = {io_addr, ~io_addr};

    ide_io_window_dec u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_progif(cfg_progif),
        .nat_cmd_base0(c0), .nat_ctl_base0(k0), .nat_cmd_base1(c1), .nat_ctl_base1(k1),
        .io_req(io_req), .io_wr(io_wr), .io_size(io_size), .io_addr(io_addr),
        .bk_rdata(bk_rdata), .io_rdata(io_rdata), .tf_stb(tf_stb), .data_stb(data_stb),
        .ctl_stb(ctl_stb), .stb_chan(stb_chan), .stb_off(stb_off), .irq_pin(irq_pin)
    );

    task automatic check(input bit ok, input string tag, input logic [38:0] act, input logic [38:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected {tf, data, ctl, chan, off[2:0], rdata[31:0]} and matched window.
    function automatic logic [38:0] model(input bit nat, input bit rq, input bit wr,
                                          input logic [1:0] sz, input logic [15:0] a,
                                          output int win);
        logic [15:0] b [4];
        logic tf = 0, dt = 0, ct = 0, ch = 0;
        logic [2:0] off = 0;
        logic [31:0] mask, rd;
        b[0] = nat ? c0 : 16'h01F0; b[1] = nat ? k0 : 16'h03F4;
        b[2] = nat ? c1 : 16'h0170; b[3] = nat ? k1 : 16'h0374;
        win = -1;
        for (int w = 3; w >= 0; w--) begin
            if ((w % 2 == 0) ? ((a >> 3) == (b[w] >> 3)) : ((a >> 2) == (b[w] >> 2))) win = w;
        end
        if (rq && win >= 0) begin
            if (win % 2 == 0) begin
                if (sz == 0) begin tf = 1; off = a[2:0]; end
                else if (a[2:0] == 0) dt = 1;
            end else if (sz == 0 && a[1:0] == 2) begin
                ct = 1; off = 3'd2;
            end
            if (tf || dt || ct) ch = (win >= 2);
        end
        mask = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        rd = 32'h0;
        if (rq && !wr) rd = (tf || dt || ct) ? ({a, ~a} & mask) : mask;
        return {tf, dt, ct, ch, off, rd};
    endfunction

    task automatic access(input bit nat, input bit rq, input bit wr, input logic [1:0] sz,
                          input logic [15:0] a, input string force_tag);
        int win;
        logic [38:0] exp, act;
        string tag;
        @(negedge clk);
        io_req = rq; io_wr = wr; io_size = sz; io_addr = a;
        #1;
        exp = model(nat, rq, wr, sz, a, win);
        act = {tf_stb, data_stb, ctl_stb, stb_chan, stb_off, io_rdata};
        if (force_tag != "")  tag = force_tag;
        else if (!rq)         tag = "R11";
        else if (win < 0)     tag = nat ? "R9/R5" : "R9/R4";
        else if (win % 2)     tag = "R6";
        else if (sz == 0)     tag = "R7";
        else                  tag = "R8";
        check(act === exp, tag, act, exp);
        io_req = 1'b0;
    endtask

    task automatic sweep(input bit nat, input string force_tag);
        logic [15:0] reg_base [8];
        reg_base[0] = 16'h01F0; reg_base[1] = 16'h03F0; reg_base[2] = 16'h0170; reg_base[3] = 16'h0370;
        reg_base[4] = c0 & 16'hFFF8; reg_base[5] = k0 & 16'hFFF8;
        reg_base[6] = c1 & 16'hFFF8; reg_base[7] = k1 & 16'hFFF8;
        for (int r = 0; r < 8; r++)
            for (int k = 0; k < 8; k++)
                for (int s = 0; s < 4; s++)
                    for (int w = 0; w < 2; w++)
                        access(nat, 1'b1, w[0], s[1:0], reg_base[r] + 16'(k), force_tag);
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_progif = v;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    task automatic check_pin(input logic exp, input string tag);
        check(irq_pin === exp, tag, {38'h0, irq_pin}, {38'h0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_pin(1'b0, "R1");
        access(1'b0, 1'b1, 1'b0, 2'd0, 16'h01F7, "R1");
        sweep(1'b0, "");
        cfg_write(8'h05); check_pin(1'b0, "R3");
        cfg_write(8'h8F); check_pin(1'b1, "R2");
        cfg_write(8'h3C); check_pin(1'b1, "R3");
        access(1'b1, 1'b1, 1'b0, 2'd0, 16'h01F7, "R3");
        sweep(1'b1, "");
        for (int k = 0; k < 8; k++) access(1'b1, 1'b0, 1'b0, 2'd0, c0 + 16'(k), "R11");
        // overlapping and misaligned native bases
        c0 = 16'hC003; k0 = 16'hC006; c1 = 16'hC001; k1 = 16'hC00A;
        sweep(1'b1, "R10");
        cfg_write(8'hFA); check_pin(1'b0, "R2");
        access(1'b0, 1'b1, 1'b0, 2'd0, 16'hC000, "R4");
        access(1'b0, 1'b1, 1'b1, 2'd2, 16'h0170, "R4");
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule